// File: doc/BRIEF.md
# Read ODT Timing Window Calculator

This block derives the on-die-termination timing window used by a DDR read path. On a start pulse it fetches a packed register that holds one read sample delay per chip select, then walks the chip selects in ascending order. It keeps the smallest delay it has seen. Each time a chip select's delay meets or exceeds the largest delay so far, it reads a phase value from every data octet lane. The window's lower edge comes from the smallest delay. The upper edge comes from the largest delay plus a margin that depends on the octet phase. Both edges are clamped and written into two fields of the ODT timing register.

All register traffic goes through one simple request port: a held request with address, write flag, data and bit mask, completed by a one-cycle acknowledge that also carries read data. The number of chip selects, the number of octets, the field positions and the register addresses are parameters.

Top module: `odt_window_calc`

## Requirements
- R1: While and after reset, `req_valid` and `done` are low until `start` is seen.
- R2: A `start` pulse in the idle state causes a read of `DLY_ADDR` as the first request.
- R3: Chip select c's sample delay is bits [c*8+3 : c*8] of the delay word. Bits 7:4 of each byte are ignored.
- R4: Chip selects are visited in ascending order. For each one whose delay is greater than or equal to the largest delay seen so far (the first always qualifies), every octet lane register is read, octet o at `LANE_BASE + 4*o` in ascending order. A chip select with a smaller delay causes no read.
- R5: An octet's phase is bits 7:6 of its lane register. Other bits, bit 5 included, are ignored. The largest phase over a scan is kept.
- R6: When a chip select's delay equals the current largest delay, the kept phase is reset to its most negative value before that chip select's scan. A strictly larger delay keeps it.
- R7: The lower edge is (smallest delay − 1) taken as unsigned. If it is 15 or more, including the wrap when the smallest delay is 0, it becomes 15. The first write goes to `ODT_ADDR` with (lower edge − 1) mod 16 in bits 15:12 and mask 0x0000F000.
- R8: The upper edge is largest delay + 4 + (phase + 1)/2 + 1, clamped to 31. The second write goes to `ODT_ADDR` with it in bits 20:16 and mask 0x001F0000.
- R9: A request holds its address, write flag and data stable until the cycle in which `req_ack` is high. One acknowledge completes one request.
- R10: `done` is high for exactly one cycle, the cycle after the second write is acknowledged. A `start` pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins one window calculation when idle |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Register request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW | Register address |
| req_wdata | output | DW | Write data |
| req_wmask | output | DW | Bits of the write that take effect |
| req_ack | input | 1 | Request completed this cycle |
| req_rdata | input | DW | Read data, valid with `req_ack` |

## Verification
The bench targets equal delays on consecutive chip selects. A design that misses the phase reset would report a margin taken from an earlier scan rather than from the last one. A strictly larger delay must keep the earlier phase, so a design that resets on every new maximum would shrink the upper edge.

A smallest delay of 0 must wrap and clamp, giving field 0xE, and a smallest delay of 1 must give field 0xF. Getting either wrong changes the lower field. All-15 delays with the top phase drive the largest upper edge.

Noise in the unused nibbles and in bit 5 of the lane registers exposes wrong field slicing. Decreasing delays must produce no lane reads. A second `start` mid-run must not produce extra requests or an extra `done`.

// File: rtl/odt_win_pkg.sv
package odt_win_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_DLY,
    S_CS_EVAL,
    S_RD_LANE,
    S_CALC,
    S_WR_LO,
    S_WR_HI
  } odt_state_e;
endpackage

// File: rtl/odt_cs_field_sel.sv
module odt_cs_field_sel #(
  parameter int DW        = 32,
  parameter int NUM_CS    = 4,
  parameter int CS_STRIDE = 8,
  parameter int SW        = 4,
  parameter int CSW       = 2
) (
  input  logic [DW-1:0]  word,
  input  logic [CSW-1:0] sel,
  output logic [SW-1:0]  field
);
  logic [SW-1:0] fields [NUM_CS];

  for (genvar c = 0; c < NUM_CS; c++) begin : g_field
    assign fields[c] = word[c*CS_STRIDE +: SW];
  end

  always_comb begin
    field = '0;
    for (int c = 0; c < NUM_CS; c++)
      if (sel == CSW'(c)) field = fields[c];
  end
endmodule

// File: rtl/odt_bound_calc.sv
module odt_bound_calc #(
  parameter int SW       = 4,
  parameter int PW       = 4,
  parameter int LO_FW    = 4,
  parameter int HI_FW    = 5,
  parameter int LO_CLAMP = 15,
  parameter int HI_CLAMP = 31
) (
  input  logic [SW-1:0]        min_s,
  input  logic [SW-1:0]        max_s,
  input  logic signed [PW-1:0] phase,
  output logic [LO_FW-1:0]     lo_field,
  output logic [HI_FW-1:0]     hi_field
);
  int lower_i;
  int upper_i;

  always_comb begin
    // unsigned semantics: a negative lower edge wraps high and clamps
    lower_i = int'(min_s) - 1;
    if (lower_i < 0 || lower_i >= LO_CLAMP) lower_i = LO_CLAMP;
    lo_field = LO_FW'(lower_i - 1);

    upper_i = int'(max_s) + 4 + (int'(phase) + 1) / 2 + 1;
    if (upper_i >= HI_CLAMP) upper_i = HI_CLAMP;
    if (upper_i < 0) upper_i = 0;
    hi_field = HI_FW'(upper_i);
  end
endmodule

// File: rtl/odt_window_calc.sv
module odt_window_calc
  import odt_win_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int NUM_CS      = 4,
  parameter int NUM_OCTETS  = 4,
  parameter int CS_STRIDE   = 8,
  parameter int SW          = 4,
  parameter int PW          = 4,
  parameter int PH_LSB      = 6,
  parameter int PH_W        = 2,
  parameter int LO_FW       = 4,
  parameter int HI_FW       = 5,
  parameter int LO_LSB      = 12,
  parameter int HI_LSB      = 16,
  parameter int LANE_STRIDE = 4,
  parameter logic [AW-1:0] DLY_ADDR  = 16'h0100,
  parameter logic [AW-1:0] LANE_BASE = 16'h0200,
  parameter logic [AW-1:0] ODT_ADDR  = 16'h0300
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          done,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic [DW-1:0] req_wmask,
  input  logic          req_ack,
  input  logic [DW-1:0] req_rdata
);
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int OCW = (NUM_OCTETS > 1) ? $clog2(NUM_OCTETS) : 1;
  localparam logic signed [PW-1:0] PH_MIN = {1'b1, {(PW-1){1'b0}}};
  localparam logic [DW-1:0] LO_MASK = DW'((2**LO_FW) - 1) << LO_LSB;
  localparam logic [DW-1:0] HI_MASK = DW'((2**HI_FW) - 1) << HI_LSB;

  odt_state_e           state;
  logic [DW-1:0]        dly_word;
  logic [CSW-1:0]       cs_idx;
  logic [OCW-1:0]       oct_idx;
  logic [SW-1:0]        max_s, min_s, cur_s;
  logic signed [PW-1:0] phase, ph_new;
  logic [LO_FW-1:0]     lo_f;
  logic [HI_FW-1:0]     hi_f;
  logic                 last_cs, last_oct;

  odt_cs_field_sel #(.DW(DW), .NUM_CS(NUM_CS), .CS_STRIDE(CS_STRIDE), .SW(SW), .CSW(CSW))
    u_sel (.word(dly_word), .sel(cs_idx), .field(cur_s));

  odt_bound_calc #(.SW(SW), .PW(PW), .LO_FW(LO_FW), .HI_FW(HI_FW))
    u_bound (.min_s(min_s), .max_s(max_s), .phase(phase), .lo_field(lo_f), .hi_field(hi_f));

  assign ph_new   = $signed({{(PW-PH_W){1'b0}}, req_rdata[PH_LSB +: PH_W]});
  assign last_cs  = (cs_idx == CSW'(NUM_CS - 1));
  assign last_oct = (oct_idx == OCW'(NUM_OCTETS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      done      <= 1'b0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_wmask <= '0;
      dly_word  <= '0;
      cs_idx    <= '0;
      oct_idx   <= '0;
      max_s     <= '0;
      min_s     <= '1;
      phase     <= PH_MIN;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          req_valid <= 1'b1;
          req_write <= 1'b0;
          req_addr  <= DLY_ADDR;
          req_wdata <= '0;
          req_wmask <= '0;
          state     <= S_RD_DLY;
        end
        S_RD_DLY: if (req_ack) begin
          dly_word  <= req_rdata;
          req_valid <= 1'b0;
          cs_idx    <= '0;
          max_s     <= '0;
          min_s     <= '1;
          phase     <= PH_MIN;
          state     <= S_CS_EVAL;
        end
        S_CS_EVAL: begin
          if (cur_s < min_s) min_s <= cur_s;
          if (cur_s >= max_s) begin
            if (cur_s == max_s) phase <= PH_MIN;
            max_s     <= cur_s;
            oct_idx   <= '0;
            req_valid <= 1'b1;
            req_addr  <= LANE_BASE;
            state     <= S_RD_LANE;
          end else if (last_cs) begin
            state <= S_CALC;
          end else begin
            cs_idx <= cs_idx + 1'b1;
          end
        end
        S_RD_LANE: if (req_ack) begin
          if (ph_new >= phase) phase <= ph_new;
          if (last_oct) begin
            req_valid <= 1'b0;
            if (last_cs) state <= S_CALC;
            else begin
              cs_idx <= cs_idx + 1'b1;
              state  <= S_CS_EVAL;
            end
          end else begin
            oct_idx  <= oct_idx + 1'b1;
            req_addr <= req_addr + AW'(LANE_STRIDE);
          end
        end
        S_CALC: begin
          req_valid <= 1'b1;
          req_write <= 1'b1;
          req_addr  <= ODT_ADDR;
          req_wdata <= DW'(lo_f) << LO_LSB;
          req_wmask <= LO_MASK;
          state     <= S_WR_LO;
        end
        S_WR_LO: if (req_ack) begin
          req_wdata <= DW'(hi_f) << HI_LSB;
          req_wmask <= HI_MASK;
          state     <= S_WR_HI;
        end
        S_WR_HI: if (req_ack) begin
          req_valid <= 1'b0;
          req_write <= 1'b0;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: a pending request is held unchanged until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) &&
                                 $stable(req_write) && $stable(req_wdata)));

  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: done follows an acknowledged write
  a_r10_done_after_wr: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req_ack && req_write));

  // R7/R8: every write targets the ODT timing register
  a_r7_wr_addr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |-> (req_addr == ODT_ADDR));

  // R5: at least one octet scan has replaced the reset phase before bounds are used
  a_r5_phase_loaded: assert property (@(posedge clk) disable iff (rst)
    (state == S_CALC) |-> (phase >= 0));
endmodule

// File: tb/odt_window_calc_tb_top.sv
module odt_window_calc_tb_top;
  localparam int NCS = 4;
  localparam int NOC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        done;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [31:0] req_wdata, req_wmask;
  logic        req_ack = 1'b0;
  logic [31:0] req_rdata = '0;

  always #2.5 clk = ~clk;

  odt_window_calc dut_i (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wmask(req_wmask),
    .req_ack(req_ack), .req_rdata(req_rdata)
  );

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] mask;
    bit          last;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          checks = 0;
  int          fails  = 0;
  int          runs_done = 0;
  int          lat = 0;
  int          waitc = 0;
  int          resp_scan = 0;
  bit          done_pend = 1'b0;
  logic [15:0] first_addr;
  logic [31:0] dly_reg;
  logic [7:0]  tab [NCS][NOC];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor and responder: one process at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (done || done_pend) chk(done == done_pend, "R10 done timing", 32'(done), 32'(done_pend));
      if (done) runs_done++;
      done_pend = 1'b0;
      if (req_ack) begin
        req_ack = 1'b0;
      end else if (req_valid) begin
        if (waitc == 0) first_addr = req_addr;
        if (waitc < lat) waitc++;
        else begin
          item_t it;
          waitc = 0;
          req_ack = 1'b1;
          chk(req_addr == first_addr, "R9 address held", 32'(req_addr), 32'(first_addr));
          if (req_write) req_rdata = '0;
          else if (req_addr == 16'h0100) req_rdata = dly_reg;
          else begin
            int o;
            o = (int'(req_addr) - 16'h0200) / 4;
            if (o < 0 || o >= NOC || resp_scan >= NCS) req_rdata = '0;
            else begin
              req_rdata = {24'hABCDE0, tab[resp_scan][o]};
              if (o == NOC - 1) resp_scan++;
            end
          end
          if (sbq.size() == 0) begin
            chk(1'b0, "R10 unexpected request", 32'(req_addr), 32'hFFFF);
          end else begin
            it = sbq.pop_front();
            chk(req_write == it.wr && req_addr == it.addr, it.tag,
                {15'd0, req_write, req_addr}, {15'd0, it.wr, it.addr});
            if (it.wr) begin
              chk(req_wdata == it.data, it.tag, req_wdata, it.data);
              chk(req_wmask == it.mask, it.tag, req_wmask, it.mask);
            end
            if (it.last) done_pend = 1'b1;
          end
        end
      end
    end
  end

  task automatic push(input bit wr, input logic [15:0] a, input logic [31:0] d,
                      input logic [31:0] m, input bit last, input string tag);
    item_t it;
    it.wr = wr; it.addr = a; it.data = d; it.mask = m; it.last = last; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic fill(input int s, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] c, input logic [7:0] d);
    tab[s][0] = a; tab[s][1] = b; tab[s][2] = c; tab[s][3] = d;
  endtask

  task automatic run_case(input logic [31:0] dly, input int latency, input bit poke);
    int mx, mn, ph, scan, lw, up, s, p, target;
    dly_reg = dly; lat = latency; resp_scan = 0;
    mx = 0; mn = 31; ph = -1024; scan = 0;
    push(1'b0, 16'h0100, '0, '0, 1'b0, "R2 first read");
    for (int c = 0; c < NCS; c++) begin
      s = int'((dly >> (c * 8)) & 32'hF);          // R3 field slicing
      if (s >= mx) begin                           // R4 scan rule
        if (s == mx) ph = -1024;                   // R6 phase reset
        mx = s;
        for (int o = 0; o < NOC; o++) begin
          push(1'b0, 16'(16'h0200 + 4 * o), '0, '0, 1'b0, "R4 lane read");
          p = int'(tab[scan][o] >> 6) & 3;         // R5 phase bits
          if (p >= ph) ph = p;
        end
        scan++;
      end
      if (s < mn) mn = s;
    end
    lw = mn - 1;
    if (lw < 0 || lw >= 15) lw = 15;
    up = mx + 4 + (ph + 1) / 2 + 1;
    if (up >= 31) up = 31;
    push(1'b1, 16'h0300, 32'((lw - 1) & 15) << 12, 32'h0000F000, 1'b0, "R7 lower write");
    push(1'b1, 16'h0300, 32'(up) << 16, 32'h001F0000, 1'b1, "R8 upper write (R6)");
    target = runs_done + 1;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    while (runs_done < target) @(posedge clk);
    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R10 all requests seen", 32'(sbq.size()), 0);
    chk(req_valid == 1'b0 && runs_done == target, "R10 idle after done",
        {31'd0, req_valid}, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < NCS; s++) fill(s, 8'h00, 8'h00, 8'h00, 8'h00);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_valid == 1'b0 && done == 1'b0, "R1 reset state", {30'd0, req_valid, done}, 0);
    #1 rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(req_valid == 1'b0 && done == 1'b0, "R1 idle after reset", {30'd0, req_valid, done}, 0);

    // R3 R5: noisy upper nibbles, rising delays, mixed phases with bit 5 set
    fill(0, 8'h40, 8'h80, 8'h20, 8'h00);
    fill(1, 8'hC0, 8'h3F, 8'h60, 8'h80);
    fill(2, 8'h3F, 8'h7F, 8'h20, 8'h40);
    run_case(32'hF9A2F7F3, 0, 1'b0);

    // R6: equal delay resets phase, later scan has phase 0; min 0 wraps (R7)
    fill(0, 8'hC0, 8'hC0, 8'hC0, 8'hC0);
    fill(1, 8'h3F, 8'h3F, 8'h3F, 8'h3F);
    run_case(32'h00010505, 1, 1'b0);

    // R6: strictly larger delay keeps the earlier phase
    fill(0, 8'hC0, 8'hC0, 8'hC0, 8'hC0);
    fill(1, 8'h00, 8'h00, 8'h00, 8'h00);
    run_case(32'h00010604, 0, 1'b0);

    // R8: all delays 15, top phase on the final scan; R7 min 15
    fill(0, 8'h00, 8'h00, 8'h00, 8'h00);
    fill(1, 8'h40, 8'h40, 8'h40, 8'h40);
    fill(2, 8'h80, 8'h00, 8'h00, 8'h00);
    fill(3, 8'h00, 8'hFF, 8'h00, 8'h00);
    run_case(32'h0F0F0F0F, 0, 1'b0);

    // R7: min 1 gives lower edge 0; R10 start during a run is ignored; R9 slow acks
    fill(0, 8'hA0, 8'h20, 8'h00, 8'h00);
    fill(1, 8'h20, 8'hA0, 8'h00, 8'h40);
    run_case(32'h01020301, 2, 1'b1);

    // R4: decreasing delays scan only once
    fill(0, 8'h80, 8'h40, 8'hC0, 8'h00);
    run_case(32'h0003080C, 1, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule